// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

A purely combinational 16-bit binary adder that adds two operands and an incoming carry and returns the 16-bit sum together with the outgoing carry. The operand width is cut into 4-bit groups. Inside each group, per-bit generate (both bits set) and propagate (either bit set) terms give every internal carry as a flat sum of products, so no carry within a group waits on another.

Each group also reduces its bits to one group propagate and one group generate term. A second lookahead unit of the same form turns those terms, together with the incoming carry, into the carry entering each group and the final carry-out. No carry ripples from one group to the next. Under equal gate delays the longest carry path is five gate levels, where a 16-bit ripple chain needs thirty-two. The block holds no state and has no handshake: the outputs follow the inputs.

Top module: `cla_adder`

## Requirements
- R1: `sum` equals the low 16 bits of `op_a + op_b + carry_in` for every input combination.
- R2: `carry_out` equals bit 16 of `op_a + op_b + carry_in`.
- R3: With `op_a` = 0xFFFF, `op_b` = 0x0000 and `carry_in` = 1, the carry propagates through all four groups, giving `sum` = 0x0000 and `carry_out` = 1.
- R4: With `op_a` = 0xFFFF, `op_b` = 0x0001 and `carry_in` = 0, a carry generated at bit 0 crosses the whole width, giving `sum` = 0x0000 and `carry_out` = 1.
- R5: When a group generates (its 4-bit slice sum of `op_a` and `op_b` exceeds 15), the carry entering the next group is 1, whatever the carry into the group.
- R6: When a group propagates but does not generate (its two slices sum to exactly 15), the carry entering the next group equals the carry entering the group.
- R7: When a group neither generates nor propagates, the carry entering the next group is 0.
- R8: For group 0 (bits 3:0), all 512 combinations of the two slices and `carry_in`, with bits 15:4 of both operands zero, give the 5-bit result in `sum[4:0]` and zeros in `sum[15:5]` and `carry_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum bits |
| carry_out | output | 1 | Carry out of bit 15 |

## Verification
The bench builds the block with its default values, a 16-bit width cut into four 4-bit groups. This setting makes one group small enough to sweep completely, and it makes all three group behaviours reachable: generate, propagate-only and kill. The boundary operands drive a carry across every group boundary at once. Random operands then exercise mixed group patterns against a bit-serial reference kept in the bench.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int unsigned CLA_WIDTH_DEF = 16;
  localparam int unsigned CLA_GROUP_DEF = 4;

  typedef struct packed {
    logic prop;
    logic gen;
  } pg_t;
endpackage

// File: rtl/cla_bit_pg.sv
module cla_bit_pg #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] gen,
  output logic [W-1:0] prop,
  output logic [W-1:0] half
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign gen[i]  = a[i] & b[i];
    assign prop[i] = a[i] | b[i];
    assign half[i] = a[i] ^ b[i];
  end
endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead
  import cla_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] gen,
  input  logic [N-1:0] prop,
  input  logic         cin,
  output logic [N-1:0] carry,
  output pg_t          blk
);
  // Flat sum-of-products per carry: no term depends on another carry.
  always_comb begin
    logic acc;
    logic term;
    carry[0] = cin;
    for (int i = 0; i < N - 1; i++) begin
      term = cin;
      for (int j = 0; j <= i; j++) term = term & prop[j];
      acc = term;
      for (int j = 0; j <= i; j++) begin
        term = gen[j];
        for (int k = j + 1; k <= i; k++) term = term & prop[k];
        acc = acc | term;
      end
      carry[i+1] = acc;
    end
  end

  always_comb begin
    logic acc;
    logic term;
    acc = 1'b0;
    for (int j = 0; j < N; j++) begin
      term = gen[j];
      for (int k = j + 1; k < N; k++) term = term & prop[k];
      acc = acc | term;
    end
    blk.gen  = acc;
    blk.prop = &prop;
  end
endmodule

// File: rtl/cla_group.sv
module cla_group
  import cla_pkg::*;
#(
  parameter int unsigned GW = 4
) (
  input  logic [GW-1:0] a,
  input  logic [GW-1:0] b,
  input  logic          cin,
  output logic [GW-1:0] sum,
  output pg_t           blk
);
  logic [GW-1:0] bit_g;
  logic [GW-1:0] bit_p;
  logic [GW-1:0] bit_x;
  logic [GW-1:0] bit_c;

  cla_bit_pg #(.W(GW)) u_pg (
    .a    (a),
    .b    (b),
    .gen  (bit_g),
    .prop (bit_p),
    .half (bit_x)
  );

  cla_lookahead #(.N(GW)) u_la (
    .gen   (bit_g),
    .prop  (bit_p),
    .cin   (cin),
    .carry (bit_c),
    .blk   (blk)
  );

  assign sum = bit_x ^ bit_c;
endmodule

// File: rtl/cla_adder.sv
module cla_adder
  import cla_pkg::*;
#(
  parameter int unsigned WIDTH = CLA_WIDTH_DEF,
  parameter int unsigned GW    = CLA_GROUP_DEF
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out
);
  localparam int unsigned NG = WIDTH / GW;

  pg_t [NG-1:0]  grp_pg;
  logic [NG-1:0] grp_g;
  logic [NG-1:0] grp_p;
  logic [NG-1:0] grp_c;
  pg_t           top_pg;

  for (genvar gi = 0; gi < NG; gi++) begin : g_grp
    cla_group #(.GW(GW)) u_grp (
      .a   (op_a[gi*GW +: GW]),
      .b   (op_b[gi*GW +: GW]),
      .cin (grp_c[gi]),
      .sum (sum[gi*GW +: GW]),
      .blk (grp_pg[gi])
    );
    assign grp_g[gi] = grp_pg[gi].gen;
    assign grp_p[gi] = grp_pg[gi].prop;
  end

  cla_lookahead #(.N(NG)) u_top (
    .gen   (grp_g),
    .prop  (grp_p),
    .cin   (carry_in),
    .carry (grp_c),
    .blk   (top_pg)
  );

  assign carry_out = top_pg.gen | (top_pg.prop & carry_in);
endmodule

// File: rtl/cla_adder_chk.sv
module cla_adder_chk #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned GW    = 4
) (
  input logic [WIDTH-1:0]    op_a,
  input logic [WIDTH-1:0]    op_b,
  input logic                carry_in,
  input logic [WIDTH-1:0]    sum,
  input logic                carry_out,
  input logic [WIDTH/GW-1:0] grp_c
);
  localparam int unsigned NG = WIDTH / GW;

  always_comb begin
    logic [WIDTH:0] ref_val;
    logic [GW:0]    slice;
    logic           nxt;
    ref_val = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
    assert_sum_R1: assert (sum == ref_val[WIDTH-1:0])
      else $error("sum mismatch");
    assert_cout_R2: assert (carry_out == ref_val[WIDTH])
      else $error("carry_out mismatch");
    for (int i = 0; i < NG; i++) begin
      slice = {1'b0, op_a[i*GW +: GW]} + {1'b0, op_b[i*GW +: GW]};
      nxt   = (i == NG - 1) ? carry_out : grp_c[(i + 1) % NG];
      if (slice[GW]) begin
        assert_gen_R5: assert (nxt == 1'b1) else $error("generate lost");
      end else if (&slice[GW-1:0]) begin
        assert_prop_R6: assert (nxt == grp_c[i]) else $error("propagate wrong");
      end else begin
        assert_kill_R7: assert (nxt == 1'b0) else $error("kill wrong");
      end
    end
  end
endmodule

bind cla_adder cla_adder_chk #(.WIDTH(WIDTH), .GW(GW)) u_chk (
  .op_a      (op_a),
  .op_b      (op_b),
  .carry_in  (carry_in),
  .sum       (sum),
  .carry_out (carry_out),
  .grp_c     (grp_c)
);

// File: tb/cla_adder_tb.sv
module cla_adder_tb;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic         carry_in = 1'b0;
  logic [W-1:0] sum;
  logic         carry_out;

  int n_run  = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  cla_adder u_dut (
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .sum       (sum),
    .carry_out (carry_out)
  );

  // Bit-serial reference, one bit per loop step.
  function automatic logic [W:0] ripple(input logic [W-1:0] a,
                                        input logic [W-1:0] b,
                                        input logic c);
    logic [W:0] r;
    logic cc;
    cc = c;
    for (int i = 0; i < W; i++) begin
      r[i] = a[i] ^ b[i] ^ cc;
      cc   = (a[i] & b[i]) | (a[i] & cc) | (b[i] & cc);
    end
    r[W] = cc;
    return r;
  endfunction

  task automatic check(input string tag, input logic [W:0] exp_v);
    n_run++;
    if ({carry_out, sum} !== exp_v) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h cin=%b: got cout=%b sum=%h, expected cout=%b sum=%h",
               tag, op_a, op_b, carry_in, carry_out, sum, exp_v[W], exp_v[W-1:0]);
    end
  endtask

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic c, input string tag);
    @(posedge clk);
    op_a <= a; op_b <= b; carry_in <= c;
    @(negedge clk);
    check(tag, ripple(a, b, c));
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("reset_R1_R2", 17'h0);
    rst = 1'b0;

    // R3: pure propagate chain across all groups
    apply(16'hFFFF, 16'h0000, 1'b1, "R3");
    check("R3_fixed", {1'b1, 16'h0000});
    // R4: generate at bit 0, carried across the width
    apply(16'hFFFF, 16'h0001, 1'b0, "R4");
    check("R4_fixed", {1'b1, 16'h0000});

    // R5: every group generates
    apply(16'h8888, 16'h8888, 1'b0, "R5");
    apply(16'h000F, 16'h0001, 1'b0, "R5_g0");
    // R6: groups propagate only, carry in 0 and 1
    apply(16'h5A5A, 16'hA5A5, 1'b0, "R6_c0");
    apply(16'h5A5A, 16'hA5A5, 1'b1, "R6_c1");
    apply(16'h0F0F, 16'h00F1, 1'b0, "R6_mix");
    // R7: groups kill
    apply(16'h1234, 16'h4321, 1'b1, "R7");
    apply(16'h0000, 16'h0000, 1'b1, "R7_zero");
    apply(16'hFFFF, 16'hFFFF, 1'b1, "R1_R2_max");
    apply(16'h8000, 16'h8000, 1'b0, "R2_top");

    // R8: exhaustive sweep of group 0
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++)
        for (int c = 0; c < 2; c++)
          apply(W'(x), W'(y), c[0], "R8");

    // R1, R2: random operands
    for (int n = 0; n < 3000; n++)
      apply(W'($urandom), W'($urandom), $urandom_range(0, 1) == 1, "R1_R2_rand");

    done = 1'b1;
    finish_run();
  end
endmodule